// File: doc/BRIEF.md
# Bus Transaction History Monitor

This block sits beside a simple request/acknowledge bus and watches it without driving it. A request is held on `bus_valid` together with its address, direction and data, and the slave accepts it by raising `bus_ready`. Each time a request closes, whether it completes normally or ends badly, the monitor writes one record into a small circular history. A record holds the address, the data, the direction and a two-bit status. Software or a debugger can then read the most recent bus cycles back, newest first, through an index input and a set of entry outputs.

Three abnormal endings are recognised. The first is a request that waits longer than a programmable number of cycles. The second is a request withdrawn before it was accepted. The third is a request whose address or direction moves while it is still pending. Each of these endings is logged with its own status code and sets a level interrupt. The interrupt stays high until it is acknowledged.

Top module: `bus_hist_mon`

## Requirements
- R1: After a synchronous active-low reset, `hist_count` is 0, `irq` is 0 and `rd_valid` is 0 for every index.
- R2: A request that sees `bus_ready` while `bus_valid` is high is logged once, with status 00. Status encoding is 00 completed, 01 timed out, 10 withdrawn, 11 protocol error. The logged address and direction are the values from the request's first cycle, and the logged data is `bus_data` in the accepting cycle.
- R3: With `cfg_limit` = L and L non-zero, a request that has `bus_ready` low in L consecutive cycles, counting its first cycle, is logged once with status 01 in the L-th cycle. A later `bus_ready` or drop of that same request logs nothing. With `cfg_limit` = 0 no timeout is ever logged.
- R4: A pending request whose `bus_valid` falls before any `bus_ready` is logged with status 10. Its data is the `bus_data` value of its last valid cycle.
- R5: If the address or the direction differs from its first-cycle value in any later valid cycle of a pending request, that request is logged with status 11 when it closes, in place of 00, 01 or 10.
- R6: The history holds 8 records. `hist_count` rises by one per record and saturates at 8. Once the history is full, each new record overwrites the oldest one. `rd_index` = 0 selects the newest record. `rd_valid` is 1 only when `rd_index` < `hist_count`.
- R7: A record with a status other than 00 sets `irq` on the following cycle. `irq` stays high until a cycle with `irq_ack` high. If a new such record is logged in the same cycle as the acknowledge, `irq` stays high.
- R8: Records with status 00 never set `irq`.
- R9: If `bus_valid` stays high in the cycle after an accepting cycle, that cycle starts a new request, which is logged separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Observed request strobe |
| bus_write | input | 1 | Observed direction, 1 = write |
| bus_addr | input | 16 | Observed address |
| bus_data | input | 16 | Observed data |
| bus_ready | input | 1 | Observed acceptance |
| cfg_limit | input | 8 | Timeout limit in cycles, 0 disables |
| irq_ack | input | 1 | Clears the interrupt |
| rd_index | input | 3 | History index, 0 = newest |
| rd_valid | output | 1 | Selected record exists |
| rd_addr | output | 16 | Selected record address |
| rd_data | output | 16 | Selected record data |
| rd_write | output | 1 | Selected record direction |
| rd_status | output | 2 | Selected record status |
| hist_count | output | 4 | Number of stored records |
| irq | output | 1 | Level interrupt |

## Verification
Some rules are checked by the assertions on every cycle:
- A completed record is only logged on a handshake cycle.
- A timeout record is only logged while the request is still waiting and a limit is set.
- A withdrawal record is only logged once `bus_valid` is low.
- The count never passes the depth and rises by exactly one per record until it is full.
- Any error record raises the interrupt.

Other behaviour only the bench scenarios can show:
- The exact timeout cycle, and silence for the rest of a timed-out request.
- Protocol-error status taking precedence over the other statuses.
- Newest-first read order across a wrap of the history.
- An acknowledge that collides with a new error.

// File: rtl/bhm_pkg.sv
// Shared widths, status codes and the history record layout.
// Assumes: address and data widths are fixed for the whole monitor.
package bhm_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_TMO   = 2'b01,
        ST_ABORT = 2'b10,
        ST_PROTO = 2'b11
    } status_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              write;
        status_t           status;
    } rec_t;
endpackage

// File: rtl/bhm_tracker.sv
// Follows one bus request at a time and emits one record when it closes.
// Closing events are acceptance, timeout, withdrawal and protocol error.
// Assumes: the bus carries at most one outstanding request. A timed-out
// request is ignored until bus_valid falls.
module bhm_tracker
    import bhm_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_ready,
    input  logic [TMO_W-1:0]  cfg_limit,
    output logic              log_en,
    output rec_t              log_rec
);
    typedef enum logic [1:0] {T_IDLE, T_PEND, T_STALE} tstate_t;

    tstate_t           st, st_nx;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_wr;
    logic [DATA_W-1:0] last_data;
    logic              viol, viol_nx;
    logic [TMO_W-1:0]  wait_cnt, wait_nx;
    logic              chg;
    logic [TMO_W:0]    wait_inc;

    assign chg      = (bus_addr != cap_addr) || (bus_write != cap_wr);
    assign wait_inc = {1'b0, wait_cnt} + 1'b1;

    // Next state and close-event decode for the current cycle.
    always_comb begin
        st_nx   = st;
        viol_nx = viol;
        wait_nx = wait_cnt;
        log_en  = 1'b0;
        log_rec = '0;
        unique case (st)
            T_IDLE: if (bus_valid) begin
                log_rec.addr  = bus_addr;
                log_rec.data  = bus_data;
                log_rec.write = bus_write;
                viol_nx       = 1'b0;
                wait_nx       = TMO_W'(1);
                if (bus_ready) begin
                    log_en         = 1'b1;
                    log_rec.status = ST_OK;
                end else if (cfg_limit == TMO_W'(1)) begin
                    log_en         = 1'b1;
                    log_rec.status = ST_TMO;
                    st_nx          = T_STALE;
                end else begin
                    st_nx = T_PEND;
                end
            end
            T_PEND: begin
                log_rec.addr  = cap_addr;
                log_rec.write = cap_wr;
                if (!bus_valid) begin
                    log_en         = 1'b1;
                    log_rec.data   = last_data;
                    log_rec.status = viol ? ST_PROTO : ST_ABORT;
                    st_nx          = T_IDLE;
                end else begin
                    log_rec.data = bus_data;
                    viol_nx      = viol | chg;
                    if (bus_ready) begin
                        log_en         = 1'b1;
                        log_rec.status = viol_nx ? ST_PROTO : ST_OK;
                        st_nx          = T_IDLE;
                    end else if (cfg_limit != '0 && wait_inc == {1'b0, cfg_limit}) begin
                        log_en         = 1'b1;
                        log_rec.status = viol_nx ? ST_PROTO : ST_TMO;
                        st_nx          = T_STALE;
                    end else if (wait_cnt != '1) begin
                        wait_nx = wait_inc[TMO_W-1:0];
                    end
                end
            end
            default: if (!bus_valid) st_nx = T_IDLE;
        endcase
    end

    // Request state and first-cycle capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= T_IDLE;
            cap_addr  <= '0;
            cap_wr    <= 1'b0;
            last_data <= '0;
            viol      <= 1'b0;
            wait_cnt  <= '0;
        end else begin
            st       <= st_nx;
            viol     <= viol_nx;
            wait_cnt <= wait_nx;
            if (bus_valid) last_data <= bus_data;
            if (st == T_IDLE && bus_valid) begin
                cap_addr <= bus_addr;
                cap_wr   <= bus_write;
            end
        end
    end

    // R2: a completed record only on a handshake cycle
    a_r2_ok_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (log_en && log_rec.status == ST_OK) |-> (bus_valid && bus_ready));
    // R3: a timeout only while still waiting with a limit set
    a_r3_tmo_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (log_en && log_rec.status == ST_TMO) |-> (bus_valid && !bus_ready && cfg_limit != '0));
    // R4: a withdrawal only once valid has dropped
    a_r4_abort_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (log_en && log_rec.status == ST_ABORT) |-> !bus_valid);
endmodule

// File: rtl/bhm_ring.sv
// Circular record store. The write pointer wraps and the count saturates.
// Reads are combinational and indexed from the newest record.
// Assumes: DEPTH is a power of two.
module bhm_ring
    import bhm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  rec_t          wr_rec,
    input  logic [IW-1:0] rd_index,
    output rec_t          rd_rec,
    output logic          rd_valid,
    output logic [IW:0]   count
);
    rec_t          slot [DEPTH];
    logic [IW-1:0] wr_ptr;
    logic [IW-1:0] rd_slot;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            // Holds one record. Loaded when the pointer selects this slot.
            always_ff @(posedge clk) begin
                if (!rst_n)                        slot[g] <= '0;
                else if (we && wr_ptr == IW'(g))   slot[g] <= wr_rec;
            end
        end
    endgenerate

    // Write pointer wrap and saturating count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (we) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (count != (IW+1)'(DEPTH)) count <= count + 1'b1;
        end
    end

    // Newest-first read mapping.
    always_comb begin
        rd_slot  = wr_ptr - IW'(1) - rd_index;
        rd_rec   = slot[rd_slot];
        rd_valid = {1'b0, rd_index} < count;
    end

    // R6: the count never passes the depth
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (IW+1)'(DEPTH));
    // R6: the count grows by one per record until full
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (we && count < (IW+1)'(DEPTH)) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/bhm_irq.sv
// Level interrupt: set by error records, cleared by acknowledge.
// A set in the same cycle as an acknowledge wins.
module bhm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic err,
    input  logic ack,
    output logic irq
);
    // Interrupt flag: set by error, cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq <= 1'b0;
        else if (err) irq <= 1'b1;
        else if (ack) irq <= 1'b0;
    end
endmodule

// File: rtl/bus_hist_mon.sv
// Passive bus transaction history monitor. It logs every closed request,
// classifies abnormal endings and raises a level interrupt on them.
// Assumes: it only observes the bus. cfg_limit is held steady by software.
module bus_hist_mon
    import bhm_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TMO_W = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_ready,
    input  logic [TMO_W-1:0]  cfg_limit,
    input  logic              irq_ack,
    input  logic [IW-1:0]     rd_index,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_write,
    output logic [1:0]        rd_status,
    output logic [IW:0]       hist_count,
    output logic              irq
);
    logic log_en;
    rec_t log_rec;
    rec_t rd_rec;
    logic err_log;

    bhm_tracker #(.TMO_W(TMO_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_ready(bus_ready),
        .cfg_limit(cfg_limit), .log_en(log_en), .log_rec(log_rec)
    );

    bhm_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .we(log_en), .wr_rec(log_rec),
        .rd_index(rd_index), .rd_rec(rd_rec), .rd_valid(rd_valid), .count(hist_count)
    );

    assign err_log = log_en && (log_rec.status != ST_OK);

    bhm_irq u_irq (.clk(clk), .rst_n(rst_n), .err(err_log), .ack(irq_ack), .irq(irq));

    assign rd_addr   = rd_rec.addr;
    assign rd_data   = rd_rec.data;
    assign rd_write  = rd_rec.write;
    assign rd_status = rd_rec.status;

    // R7: any error record raises the interrupt
    a_r7_irq_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (log_en && log_rec.status != ST_OK) |=> irq);
    // R8: no error record and no prior interrupt keeps it low
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(log_en && log_rec.status != ST_OK)) |=> !irq);
endmodule

// File: tb/bus_hist_mon_test.sv
module bus_hist_mon_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_ready = 1'b0;
    logic [15:0] bus_addr = '0, bus_data = '0;
    logic [7:0]  cfg_limit = 8'd16;
    logic        irq_ack = 1'b0;
    logic [2:0]  rd_index = '0;
    logic        rd_valid, rd_write, irq;
    logic [15:0] rd_addr, rd_data;
    logic [1:0]  rd_status;
    logic [3:0]  hist_count;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] d;
        logic        w;
        logic [1:0]  s;
    } exp_t;
    exp_t exp_q[$];

    bus_hist_mon uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_ready(bus_ready),
        .cfg_limit(cfg_limit), .irq_ack(irq_ack), .rd_index(rd_index),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_write(rd_write), .rd_status(rd_status), .hist_count(hist_count), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Driver side: push the record the requirements predict, newest first.
    task automatic push(input logic [15:0] a, input logic [15:0] d, input logic w, input logic [1:0] s);
        exp_t e;
        e.a = a; e.d = d; e.w = w; e.s = s;
        exp_q.push_front(e);
        if (exp_q.size() > DEPTH) void'(exp_q.pop_back());
    endtask

    // Monitor side: read history newest first and compare with the queue.
    task automatic check_hist(input string tag);
        repeat (2) @(negedge clk);
        chk({tag, " R6 count"}, 32'(hist_count), 32'(exp_q.size()));
        for (int i = 0; i < exp_q.size(); i++) begin
            rd_index = 3'(i);
            #1;
            chk({tag, " R6 valid"}, 32'(rd_valid), 32'd1);
            chk({tag, " addr"},     32'(rd_addr),  32'(exp_q[i].a));
            chk({tag, " data"},     32'(rd_data),  32'(exp_q[i].d));
            chk({tag, " dir"},      32'(rd_write), 32'(exp_q[i].w));
            chk({tag, " status"},   32'(rd_status), 32'(exp_q[i].s));
        end
        rd_index = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
    endtask

    task automatic ack_irq();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic xfer(input logic w, input logic [15:0] a, input logic [15:0] d, input int waits);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_data = d; bus_ready = (waits == 0);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            if (i == waits - 1) bus_ready = 1'b1;
        end
        @(negedge clk);
        bus_valid = 1'b0; bus_ready = 1'b0;
        push(a, d, w, 2'b00);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R1: reset state
        chk("R1 count", 32'(hist_count), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rd_valid", 32'(rd_valid), 0);

        // R2 / R8: completed transfers, zero and several wait cycles
        xfer(1'b1, 16'h1000, 16'hAAAA, 0);
        xfer(1'b0, 16'h2000, 16'h5555, 3);
        check_hist("R2 basic");
        chk("R8 no irq on ok", 32'(irq), 0);

        // R9: back-to-back handshakes
        @(negedge clk);
        bus_valid = 1; bus_ready = 1; bus_write = 1; bus_addr = 16'h2100; bus_data = 16'h0001;
        @(negedge clk);
        bus_write = 0; bus_addr = 16'h2200; bus_data = 16'h0002;
        @(negedge clk);
        bus_valid = 0; bus_ready = 0;
        push(16'h2100, 16'h0001, 1'b1, 2'b00);
        push(16'h2200, 16'h0002, 1'b0, 2'b00);
        check_hist("R9 b2b");

        // R3: timeout at limit 4, late ready ignored
        cfg_limit = 8'd4;
        @(negedge clk);
        bus_valid = 1; bus_ready = 0; bus_write = 1; bus_addr = 16'h3000; bus_data = 16'h3333;
        repeat (6) @(negedge clk);
        bus_ready = 1;
        @(negedge clk);
        bus_valid = 0; bus_ready = 0;
        push(16'h3000, 16'h3333, 1'b1, 2'b01);
        check_hist("R3 timeout");
        chk("R7 irq set", 32'(irq), 1);
        ack_irq();
        #1;
        chk("R7 irq cleared", 32'(irq), 0);

        // R4: withdrawal, data from the last valid cycle
        cfg_limit = 8'd16;
        @(negedge clk);
        bus_valid = 1; bus_ready = 0; bus_write = 0; bus_addr = 16'h4000; bus_data = 16'h4441;
        @(negedge clk);
        bus_data = 16'h4442;
        @(negedge clk);
        bus_valid = 0;
        push(16'h4000, 16'h4442, 1'b0, 2'b10);
        check_hist("R4 abort");
        chk("R7 irq abort", 32'(irq), 1);
        ack_irq();

        // R5: address moves while pending, then accepted
        @(negedge clk);
        bus_valid = 1; bus_ready = 0; bus_write = 1; bus_addr = 16'h5000; bus_data = 16'h5555;
        @(negedge clk);
        bus_addr = 16'h5004;
        @(negedge clk);
        bus_ready = 1; bus_data = 16'h5556;
        @(negedge clk);
        bus_valid = 0; bus_ready = 0;
        push(16'h5000, 16'h5556, 1'b1, 2'b11);
        check_hist("R5 addr move");

        // R5: direction flips while pending, then withdrawn
        @(negedge clk);
        bus_valid = 1; bus_ready = 0; bus_write = 0; bus_addr = 16'h5100; bus_data = 16'h0051;
        @(negedge clk);
        bus_write = 1;
        @(negedge clk);
        bus_valid = 0;
        push(16'h5100, 16'h0051, 1'b0, 2'b11);
        check_hist("R5 dir flip");

        // R3: limit 0 disables the timeout
        cfg_limit = 8'd0;
        xfer(1'b0, 16'h6000, 16'h6666, 40);
        check_hist("R3 limit0");
        cfg_limit = 8'd16;

        // R7: irq is still set; an acknowledge colliding with a new error loses
        chk("R7 irq still set", 32'(irq), 1);
        cfg_limit = 8'd1;
        @(negedge clk);
        bus_valid = 1; bus_ready = 0; bus_write = 0; bus_addr = 16'h7000; bus_data = 16'h7777;
        irq_ack = 1;
        @(negedge clk);
        chk("R7 ack collision", 32'(irq), 1);
        bus_valid = 0; irq_ack = 0;
        push(16'h7000, 16'h7777, 1'b0, 2'b01);
        check_hist("R3 limit1");
        ack_irq();
        #1;
        chk("R7 irq after ack", 32'(irq), 0);
        cfg_limit = 8'd16;

        // R6: partial fill, then wrap
        do_reset();
        for (int i = 0; i < 3; i++) xfer(1'b1, 16'h0100 + 16'(i), 16'h0A00 + 16'(i), 1);
        repeat (2) @(negedge clk);
        rd_index = 3'd3; #1;
        chk("R6 valid beyond count", 32'(rd_valid), 0);
        rd_index = 3'd2; #1;
        chk("R6 valid within count", 32'(rd_valid), 1);
        for (int i = 3; i < 10; i++) xfer(1'b0, 16'h0100 + 16'(i), 16'h0A00 + 16'(i), 0);
        check_hist("R6 wrap");
        chk("R6 saturate", 32'(hist_count), 8);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule